// File: doc/BRIEF.md
# Dual Addressable Latch with Demultiplex Mode

This block holds two independent four-bit storage banks, a and b, that share one two-bit bit-select, one active-low write enable and one active-low clear. Each bank has its own serial data input and a four-bit parallel output. The enable and clear pins together pick one of four operating modes. The block can wipe both banks, route each bank's data input to one addressed bit while all other bits are zero, write one addressed bit while the rest keep their contents, or hold everything.

The storage is built from clocked registers instead of level-sensitive latches. Every rising edge samples the control pins, the bit-select and the data inputs, and the outputs show the new contents one cycle later. A typical use is serial-to-parallel loading, where one bit is written per cycle at a chosen index and the bank then goes into hold mode. Address changes belong in hold mode. Because the design is clocked, an address that moves while writing only affects the bit sampled at that edge.

Top module: `dual_addr_latch`

## Requirements
- R1: While the synchronous active-low reset is low at a rising edge, all eight output bits become 0 after that edge.
- R2: Clear mode (enable_n = 1, clear_n = 0) makes all eight output bits 0 one cycle later, whatever the data and address inputs are.
- R3: Demultiplex mode (enable_n = 0, clear_n = 0) sets, in each bank, the addressed output bit to that bank's sampled data input and the other three bits to 0, one cycle later.
- R4: Latch mode (enable_n = 0, clear_n = 1) loads, in each bank, the addressed bit from that bank's sampled data input one cycle later, and the other three bits keep their values.
- R5: Hold mode (enable_n = 1, clear_n = 1) keeps all eight bits unchanged, even when the data and address inputs change.
- R6: The bit-select value k (0 to 3) addresses output bit k, bit 0 being the least significant bit of each output bus. The same index applies to both banks.
- R7: The banks are independent. Bank a takes its value only from data_a and bank b only from data_b.
- R8: When several latch-mode cycles write the same bit and the block then goes into hold mode, the value sampled on the last latch-mode edge is the one kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_sel | input | 2 | Index of the bit to write, shared by both banks |
| wr_en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low clear |
| data_a | input | 1 | Data input of bank a |
| data_b | input | 1 | Data input of bank b |
| q_a | output | 4 | Stored bits of bank a |
| q_b | output | 4 | Stored bits of bank b |

## Verification
The assertions check the per-mode update rule on every cycle, in both banks. Clear mode must zero the bank, demultiplex mode must give exactly the shifted data bit, latch mode must change only the addressed bit, and hold mode must keep the outputs stable. The bench scenarios cover what a single-cycle rule cannot show: that every index reaches the right physical bit, that the banks stay separate when their data differ, that a value written earlier survives long stretches of hold mode with the address and data changing, and that the last of several writes to the same bit is the one kept.

// File: rtl/dal_pkg.sv
// Shared types for the dual addressable latch.
// Assumes: the two control pins are active low and already synchronous to clk.
package dal_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_DEMUX = 2'd1,
        MODE_LATCH = 2'd2,
        MODE_HOLD  = 2'd3
    } dal_mode_e;

    // Maps the (enable_n, clear_n) pair to an operating mode.
    function automatic dal_mode_e decode_mode(input logic en_n, input logic clr_n);
        dal_mode_e m;
        case ({en_n, clr_n})
            2'b10:   m = MODE_CLEAR;
            2'b00:   m = MODE_DEMUX;
            2'b01:   m = MODE_LATCH;
            default: m = MODE_HOLD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dal_ctrl.sv
// Mode decoder shared by both banks.
// Produces a one-hot write select (empty in clear and hold modes) and a flag
// that forces every unselected bit to zero (clear and demultiplex modes).
// Assumes: bit_sel is below BITS; higher values select nothing.
module dal_ctrl
    import dal_pkg::*;
#(
    parameter int BITS   = 4,
    parameter int ADDR_W = (BITS > 1) ? $clog2(BITS) : 1
) (
    input  logic              wr_en_n,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] bit_sel,
    output logic [BITS-1:0]   load_sel,
    output logic              zero_rest
);

    dal_mode_e mode;
    logic      write_mode;

    // Decode the control pins into a mode and derived strobes.
    always_comb begin
        mode       = decode_mode(wr_en_n, clr_n);
        write_mode = (mode == MODE_DEMUX) || (mode == MODE_LATCH);
        zero_rest  = (mode == MODE_CLEAR) || (mode == MODE_DEMUX);
    end

    // One select line per storage bit, active when its index is addressed.
    for (genvar i = 0; i < BITS; i++) begin : g_sel
        assign load_sel[i] = write_mode && (bit_sel == ADDR_W'(i));
    end

endmodule

// File: rtl/dal_bank.sv
// One bank of storage bits with a load enable per bit.
// A selected bit loads din, an unselected bit is zeroed when zero_rest is
// set and holds otherwise.
// Assumes: load_sel has at most one bit set.
module dal_bank #(
    parameter int BITS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            din,
    input  logic [BITS-1:0] load_sel,
    input  logic            zero_rest,
    output logic [BITS-1:0] q
);

    for (genvar i = 0; i < BITS; i++) begin : g_bit
        // Update storage bit i: reset, load, force to zero, or hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (load_sel[i])
                q[i] <= din;
            else if (zero_rest)
                q[i] <= 1'b0;
        end
    end

    // R6: the decoder never selects two bits of a bank at once.
    always_comb begin
        assert_single_select_R6: assert ($onehot0(load_sel));
    end

endmodule

// File: rtl/dual_addr_latch.sv
// Top of the dual addressable latch: two banks driven by one mode decoder.
// Outputs are registered and show the effect of the inputs one cycle after
// the rising edge that sampled them.
// Assumes: all inputs are synchronous to clk.
module dual_addr_latch #(
    parameter int BITS   = 4,
    parameter int ADDR_W = (BITS > 1) ? $clog2(BITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bit_sel,
    input  logic              wr_en_n,
    input  logic              clr_n,
    input  logic              data_a,
    input  logic              data_b,
    output logic [BITS-1:0]   q_a,
    output logic [BITS-1:0]   q_b
);

    localparam int NUM_BANKS = 2;

    logic [BITS-1:0] load_sel;
    logic            zero_rest;
    logic [NUM_BANKS-1:0] din_vec;
    logic [BITS-1:0]      q_vec [NUM_BANKS];

    // Gather the per-bank data inputs into one vector.
    assign din_vec = {data_b, data_a};

    dal_ctrl #(
        .BITS   (BITS),
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .wr_en_n   (wr_en_n),
        .clr_n     (clr_n),
        .bit_sel   (bit_sel),
        .load_sel  (load_sel),
        .zero_rest (zero_rest)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dal_bank #(
            .BITS (BITS)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .din       (din_vec[b]),
            .load_sel  (load_sel),
            .zero_rest (zero_rest),
            .q         (q_vec[b])
        );
    end

    // Route bank storage to the named output buses.
    assign q_a = q_vec[0];
    assign q_b = q_vec[1];

    // R2: clear mode empties both banks.
    assert_clear_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_n && !clr_n) |=> (q_a == '0) && (q_b == '0));

    // R3: demultiplex mode shows only the addressed bit, carrying data.
    assert_demux_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && !clr_n) |=>
            (q_a == (BITS'($past(data_a)) << $past(bit_sel))) &&
            (q_b == (BITS'($past(data_b)) << $past(bit_sel))));

    // R4: latch mode writes the addressed bit and leaves the others alone.
    assert_latch_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && clr_n) |=>
            (q_a == (($past(q_a) & ~(BITS'(1) << $past(bit_sel))) |
                     (BITS'($past(data_a)) << $past(bit_sel)))) &&
            (q_b == (($past(q_b) & ~(BITS'(1) << $past(bit_sel))) |
                     (BITS'($past(data_b)) << $past(bit_sel)))));

    // R5: hold mode keeps every output bit.
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_n && clr_n) |=> $stable(q_a) && $stable(q_b));

endmodule

// File: tb/dual_addr_latch_test.sv
// Self-checking bench: directed corner cases followed by seeded random stimulus,
// compared against a reference model written as bench functions.
module dual_addr_latch_test;

    localparam int BITS = 4;
    localparam int AW   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bit_sel = '0;
    logic          wr_en_n = 1'b1;
    logic          clr_n = 1'b1;
    logic          data_a = 1'b0;
    logic          data_b = 1'b0;
    logic [BITS-1:0] q_a, q_b;

    logic [BITS-1:0] exp_a = '0;
    logic [BITS-1:0] exp_b = '0;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    dual_addr_latch #(.BITS(BITS), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bit_sel(bit_sel), .wr_en_n(wr_en_n),
        .clr_n(clr_n), .data_a(data_a), .data_b(data_b), .q_a(q_a), .q_b(q_b)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Reference next state of one bank, written from the requirements.
    function automatic logic [BITS-1:0] model_next(input logic [BITS-1:0] cur,
            input logic en_n, input logic cl_n, input logic [AW-1:0] sel, input logic d);
        logic [BITS-1:0] r;
        r = cur;
        if (en_n && !cl_n)       r = '0;                          // R2
        else if (!en_n && !cl_n) begin r = '0; r[sel] = d; end     // R3
        else if (!en_n && cl_n)  r[sel] = d;                      // R4
        return r;                                                  // R5 hold
    endfunction

    task automatic check(input string tag, input logic [BITS-1:0] act_a,
            input logic [BITS-1:0] act_b, input logic [BITS-1:0] ea, input logic [BITS-1:0] eb);
        checks++;
        if (act_a !== ea || act_b !== eb) begin
            fails++;
            $display("FAIL %s: q_a=%b q_b=%b expected q_a=%b q_b=%b", tag, act_a, act_b, ea, eb);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, then check after the rising edge.
    task automatic step(input logic en_n, input logic cl_n, input logic [AW-1:0] sel,
            input logic da, input logic db, input string tag);
        @(negedge clk);
        wr_en_n = en_n; clr_n = cl_n; bit_sel = sel; data_a = da; data_b = db;
        @(posedge clk);
        exp_a = model_next(exp_a, en_n, cl_n, sel, da);
        exp_b = model_next(exp_b, en_n, cl_n, sel, db);
        #1;
        check(tag, q_a, q_b, exp_a, exp_b);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state, with data inputs active.
        wr_en_n = 1'b0; clr_n = 1'b1; data_a = 1'b1; data_b = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R1 reset", q_a, q_b, '0, '0);
        @(negedge clk);
        rst_n = 1'b1; wr_en_n = 1'b1;

        // R4/R6/R7: latch distinct patterns into each index of each bank.
        for (int k = 0; k < BITS; k++)
            step(1'b0, 1'b1, AW'(k), k[0], ~k[0], "R4 R6 R7 latch per index");
        check("R6 bank a index map", q_a, q_b, 4'b1010, 4'b0101);

        // R5: hold with address and data moving.
        for (int k = 0; k < 6; k++)
            step(1'b1, 1'b1, AW'(k), ~k[0], k[0], "R5 hold");
        check("R5 hold retained", q_a, q_b, 4'b1010, 4'b0101);

        // R8: several writes to bit 2, last one kept through hold.
        step(1'b0, 1'b1, 2'd2, 1'b0, 1'b1, "R8 write 1");
        step(1'b0, 1'b1, 2'd2, 1'b1, 1'b0, "R8 write 2");
        step(1'b0, 1'b1, 2'd2, 1'b0, 1'b1, "R8 write 3");
        step(1'b1, 1'b1, 2'd0, 1'b1, 1'b0, "R8 hold");
        check("R8 last value kept", q_a, q_b, 4'b1010, 4'b0101);

        // R3: demultiplex at every index, banks with opposite data.
        for (int k = 0; k < BITS; k++) begin
            step(1'b0, 1'b0, AW'(k), 1'b1, 1'b0, "R3 demux a high");
            check("R3 R6 demux one-hot", q_a, q_b, 4'(1) << k, 4'b0000);
        end
        step(1'b0, 1'b0, 2'd1, 1'b0, 1'b1, "R3 R7 demux b high");

        // R2: clear after refilling everything.
        for (int k = 0; k < BITS; k++)
            step(1'b0, 1'b1, AW'(k), 1'b1, 1'b1, "R4 fill");
        step(1'b1, 1'b0, 2'd3, 1'b1, 1'b1, "R2 clear");
        check("R2 all zero", q_a, q_b, '0, '0);

        // R1: reset in the middle of operation.
        step(1'b0, 1'b1, 2'd0, 1'b1, 1'b1, "R4 before reset");
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        exp_a = '0; exp_b = '0;
        check("R1 mid-run reset", q_a, q_b, '0, '0);
        @(negedge clk); rst_n = 1'b1; wr_en_n = 1'b1; clr_n = 1'b1;

        // Random stimulus across all modes (R2 R3 R4 R5 R6 R7).
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] m;
            m = 2'($urandom_range(0, 3));
            step(m[1], m[0], AW'($urandom_range(0, BITS - 1)),
                 1'($urandom), 1'($urandom), "R2 R3 R4 R5 random");
        end
        finish_run();
    end

endmodule